// File: doc/BRIEF.md
# Truecolor DAC Register Interface

This block is the processor-facing register front end of a truecolor video DAC. A 4-bit address and an 8-bit data bus reach two resources. The four lowest addresses are VGA-style palette ports: a write index, a data port, a pixel mask and a read index. Through the data port, software reaches a 256-entry colour table whose entries are red, green and blue bytes, one component per access. Every other address reaches a control register file.

One control register holds a mode code. Its decoded pixel format is a registered 3-bit output that tells the pixel pipeline how to unpack video memory. A second control register selects 6-bit or 8-bit palette entries and records the size of video memory. Several addresses always read back fixed identification bytes, whatever was last written to them. Software programs the palette by loading an index and streaming component bytes, and switches video modes with a single write to the mode register.

Top module: `dac_regif`

## Requirements
- R1: After reset, pixel_fmt is 1 (8 bpp), dac_6bit and mem_size are 0, both palette indices read 0, the pixel mask reads 0xFF and every control register reads 0 except at the fixed readback addresses.
- R2: A write to address 0 loads the palette write index and a write to address 3 loads the palette read index. Each such write restarts that direction's component sequence at red. A read of address 0 returns the write index and a read of address 3 returns the read index, with no side effect.
- R3: Each write to address 1 stores the byte into the current component of the entry at the write index, in the order red, green, blue. After the blue write the write index advances by one, wrapping from 255 to 0.
- R4: Each read of address 1 returns the current component of the entry at the read index, in the same red, green, blue order. After the blue read the read index advances by one, wrapping from 255 to 0.
- R5: Address 2 holds the pixel mask byte: a write stores it and a read returns it.
- R6: Bit 0 of register 0x0C drives dac_6bit. While it is 1, a palette write stores only the low 6 bits and a palette read returns the stored value with bits 7:6 forced to zero. While it is 0, all 8 bits are stored and returned.
- R7: A write to any address from 4 to 15 stores the byte in the control register at that address, and a read returns it unless R8 applies. Writes to addresses 0 to 3 never change pixel_fmt, dac_6bit or mem_size.
- R8: Reads of addresses 4 and 8 return 0x02, reads of 6 and 0x0A return 0x1D, and a read of 0x0F returns 0xD0, regardless of what was written there.
- R9: A write to register 0x0B sets pixel_fmt from the code: 0x82 gives 0 (4 bpp), 0x83 gives 1 (8 bpp), 0xA0 gives 2 (15 bpp), 0xA1 and 0xB1 give 3 (16 bpp), 0xC0 and 0xD0 give 4 (24 bpp), 0xE2 gives 5 (32 bpp) and 0xF2 gives 6 (32 bpp RGBA order). Any other code gives 1.
- R10: pixel_fmt is registered. It takes its new value on the clock edge that accepts the write to 0x0B, and it holds its value on every edge without such a write.
- R11: mem_size always equals bits 3:2 of register 0x0C (1: under 1 MB, 2: 1 MB, 3: more than 1 MB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe; the data is valid in the same cycle and any sequencing effect happens at the edge |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| pixel_fmt | output | 3 | Decoded pixel format code |
| dac_6bit | output | 1 | High when palette entries are 6 bits wide |
| mem_size | output | 2 | Video memory size field |

## Verification
A component counter that drifts shows up at the data port on the very next access: a byte lands in the wrong colour, or a read returns a neighbouring component. Because the index only moves after blue, a fault stays visible on every later palette read. A wrong mode decode or an early or late format update appears on pixel_fmt within one edge of the mode write, and the reference model compares that output on every clock. Width-trimming faults show in the upper two bits of the first palette read after dac_6bit changes.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

  typedef enum logic [2:0] {
    PIX_4BPP    = 3'd0,
    PIX_8BPP    = 3'd1,
    PIX_15BPP   = 3'd2,
    PIX_16BPP   = 3'd3,
    PIX_24BPP   = 3'd4,
    PIX_32BPP   = 3'd5,
    PIX_32_RGBA = 3'd6
  } pix_fmt_e;

  // Mode code to pixel format; unknown codes fall back to 8 bpp.
  function automatic pix_fmt_e decode_mode(input logic [7:0] code);
    pix_fmt_e f;
    case (code)
      8'h82:         f = PIX_4BPP;
      8'h83:         f = PIX_8BPP;
      8'hA0:         f = PIX_15BPP;
      8'hA1, 8'hB1:  f = PIX_16BPP;
      8'hC0, 8'hD0:  f = PIX_24BPP;
      8'hE2:         f = PIX_32BPP;
      8'hF2:         f = PIX_32_RGBA;
      default:       f = PIX_8BPP;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/dac_palette.sv
module dac_palette #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int COMP_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_idx_we,
  input  logic              rd_idx_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic              mask_we,
  input  logic              six_bit,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] mask_q
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int COMP_W = (COMP_N > 1) ? $clog2(COMP_N) : 1;
  localparam logic [COMP_W-1:0] LAST_COMP = COMP_W'(COMP_N - 1);
  localparam logic [DATA_W-1:0] SIX_MASK  = DATA_W'((1 << (DATA_W - 2)) - 1);

  function automatic logic [COMP_W-1:0] comp_step(input logic [COMP_W-1:0] c);
    return (c == LAST_COMP) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] width_trim(input logic [DATA_W-1:0] d,
                                                   input logic six);
    return six ? (d & SIX_MASK) : d;
  endfunction

  logic [COMP_W-1:0] wr_comp, rd_comp;

  // named events for the checks
  logic pal_wr_ev, pal_rd_ev, wr_wrap_ev, rd_wrap_ev;
  assign pal_wr_ev  = data_we;
  assign pal_rd_ev  = data_re;
  assign wr_wrap_ev = pal_wr_ev && (wr_comp == LAST_COMP);
  assign rd_wrap_ev = pal_rd_ev && (rd_comp == LAST_COMP);

  logic [DATA_W-1:0] store_val;
  assign store_val = width_trim(wdata, six_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      wr_comp <= '0;
    end else if (wr_idx_we) begin
      wr_idx  <= wdata[IDX_W-1:0];
      wr_comp <= '0;
    end else if (pal_wr_ev) begin
      wr_comp <= comp_step(wr_comp);
      if (wr_wrap_ev) wr_idx <= wr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      rd_comp <= '0;
    end else if (rd_idx_we) begin
      rd_idx  <= wdata[IDX_W-1:0];
      rd_comp <= '0;
    end else if (pal_rd_ev) begin
      rd_comp <= comp_step(rd_comp);
      if (rd_wrap_ev) rd_idx <= rd_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= wdata;
  end

  // one storage bank per colour component
  logic [DATA_W-1:0] comp_rd [COMP_N];

  for (genvar c = 0; c < COMP_N; c++) begin : g_bank
    logic [DATA_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (pal_wr_ev && (wr_comp == COMP_W'(c))) bank[wr_idx] <= store_val;
    end
    assign comp_rd[c] = bank[rd_idx];
  end

  logic [DATA_W-1:0] raw_q;
  always_comb begin
    raw_q = '0;
    for (int c = 0; c < COMP_N; c++) begin
      if (rd_comp == COMP_W'(c)) raw_q = comp_rd[c];
    end
  end
  assign data_q = width_trim(raw_q, six_bit);

  // R2
  widx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_we |=> (wr_comp == '0) && (wr_idx == $past(wdata[IDX_W-1:0])));

  // R3
  widx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wrap_ev && !wr_idx_we) |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)) && (wr_comp == '0));

  // R3
  wcomp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_wr_ev && !wr_idx_we) |=> (wr_comp != $past(wr_comp)));

  // R4
  ridx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wrap_ev && !rd_idx_we) |=> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)) && (rd_comp == '0));

  // R4
  ridx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_idx_we && !pal_rd_ev) |=> $stable(rd_idx) && $stable(rd_comp));

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_regif_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int FIRST_REG = 4,
  parameter int MODE_REG  = 11,
  parameter int SETUP_REG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output pix_fmt_e          pix_fmt,
  output logic              six_bit,
  output logic [1:0]        mem_size
);

  localparam int NREG = 1 << ADDR_W;

  // fixed identification bytes: {hit, value}
  function automatic logic [DATA_W:0] fixed_readback(input logic [ADDR_W-1:0] a);
    logic [DATA_W:0] r;
    case (a)
      ADDR_W'(4), ADDR_W'(8):  r = {1'b1, DATA_W'(8'h02)};
      ADDR_W'(6), ADDR_W'(10): r = {1'b1, DATA_W'(8'h1D)};
      ADDR_W'(15):             r = {1'b1, DATA_W'(8'hD0)};
      default:                 r = '0;
    endcase
    return r;
  endfunction

  logic [DATA_W-1:0] regs [NREG];

  logic mode_wr_ev;
  assign mode_wr_ev = wr_en && (addr == ADDR_W'(MODE_REG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int i = FIRST_REG; i < NREG; i++) begin
        if (addr == ADDR_W'(i)) regs[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          pix_fmt <= PIX_8BPP;
    else if (mode_wr_ev) pix_fmt <= decode_mode(wdata[7:0]);
  end

  logic [DATA_W:0] fixed_hit;
  assign fixed_hit = fixed_readback(addr);
  assign rd_data   = fixed_hit[DATA_W] ? fixed_hit[DATA_W-1:0] : regs[addr];

  assign six_bit  = regs[SETUP_REG][0];
  assign mem_size = regs[SETUP_REG][3:2];

  // R10
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_ev |=> $stable(pix_fmt));

  // R9
  fmt_rgba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_ev && wdata[7:0] == 8'hF2) |=> (pix_fmt == PIX_32_RGBA));

  // R9
  fmt_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_ev && wdata[7:0] == 8'h00) |=> (pix_fmt == PIX_8BPP));

endmodule

// File: rtl/dac_regif.sv
module dac_regif
  import dac_regif_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 8,
  parameter int COMP_N    = 3,
  parameter int FIRST_REG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [2:0]        pixel_fmt,
  output logic              dac_6bit,
  output logic [1:0]        mem_size
);

  localparam logic [ADDR_W-1:0] A_WIDX  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RIDX  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(FIRST_REG);

  logic pal_sel, ctrl_sel;
  assign ctrl_sel = (bus_addr >= A_FIRST);
  assign pal_sel  = !ctrl_sel;

  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] pal_data, pal_mask, ctrl_rd;
  logic              six_bit;
  pix_fmt_e          fmt_q;

  dac_palette #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .COMP_N(COMP_N)
  ) u_palette (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_idx_we(bus_wr && bus_addr == A_WIDX),
    .rd_idx_we(bus_wr && bus_addr == A_RIDX),
    .data_we  (bus_wr && bus_addr == A_DATA),
    .data_re  (bus_rd && !bus_wr && bus_addr == A_DATA),
    .mask_we  (bus_wr && bus_addr == A_MASK),
    .six_bit  (six_bit),
    .wdata    (bus_wdata),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .data_q   (pal_data),
    .mask_q   (pal_mask)
  );

  dac_ctrl_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FIRST_REG(FIRST_REG)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && ctrl_sel),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rd_data (ctrl_rd),
    .pix_fmt (fmt_q),
    .six_bit (six_bit),
    .mem_size(mem_size)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (pal_sel) begin
        case (bus_addr)
          A_WIDX:  bus_rdata = DATA_W'(wr_idx);
          A_DATA:  bus_rdata = pal_data;
          A_MASK:  bus_rdata = pal_mask;
          default: bus_rdata = DATA_W'(rd_idx);
        endcase
      end else begin
        bus_rdata = ctrl_rd;
      end
    end
  end

  assign pixel_fmt = fmt_q;
  assign dac_6bit  = six_bit;

  // R6
  six_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && dac_6bit) |-> (bus_rdata[7:6] == 2'b00));

  // R8
  id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(15)) |-> (bus_rdata == DATA_W'(8'hD0)));

  // R7
  low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && pal_sel) |=> $stable(pixel_fmt) && $stable(dac_6bit) && $stable(mem_size));

endmodule

// File: tb/dac_regif_tb.sv
`timescale 1ns/1ps
module dac_regif_tb;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_wr = 0;
  logic       bus_rd = 0;
  logic [7:0] bus_rdata;
  logic [2:0] pixel_fmt;
  logic       dac_6bit;
  logic [1:0] mem_size;

  always #4 clk = ~clk;

  dac_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pixel_fmt(pixel_fmt), .dac_6bit(dac_6bit), .mem_size(mem_size)
  );

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit done = 0;

  // reference model
  int m_widx, m_ridx, m_wc, m_rc, m_mask, m_fmt;
  int m_pal [256][3];
  int m_reg [16];

  function automatic int fmt_of(int code);
    if (code == 'h82) return 0;
    if (code == 'hA0) return 2;
    if (code == 'hA1 || code == 'hB1) return 3;
    if (code == 'hC0 || code == 'hD0) return 4;
    if (code == 'hE2) return 5;
    if (code == 'hF2) return 6;
    return 1;
  endfunction

  function automatic int m_six();
    return m_reg[12] % 2;
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return m_widx;
      1: return m_six() ? (m_pal[m_ridx][m_rc] % 64) : m_pal[m_ridx][m_rc];
      2: return m_mask;
      3: return m_ridx;
      4, 8: return 'h02;
      6, 10: return 'h1D;
      15: return 'hD0;
      default: return m_reg[a];
    endcase
  endfunction

  task automatic m_reset();
    m_widx = 0; m_ridx = 0; m_wc = 0; m_rc = 0; m_mask = 255; m_fmt = 1;
    foreach (m_reg[i]) m_reg[i] = 0;
    foreach (m_pal[i, j]) m_pal[i][j] = 0;
  endtask

  task automatic m_apply(bit w, bit r, int a, int d);
    if (w) begin
      case (a)
        0: begin m_widx = d; m_wc = 0; end
        1: begin
          m_pal[m_widx][m_wc] = m_six() ? d % 64 : d;
          m_wc++;
          if (m_wc == 3) begin m_wc = 0; m_widx = (m_widx + 1) % 256; end
        end
        2: m_mask = d;
        3: begin m_ridx = d; m_rc = 0; end
        default: begin
          m_reg[a] = d;
          if (a == 11) m_fmt = fmt_of(d);
        end
      endcase
    end else if (r && a == 1) begin
      m_rc++;
      if (m_rc == 3) begin m_rc = 0; m_ridx = (m_ridx + 1) % 256; end
    end
  endtask

  task automatic check(int got, int exp, string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic op(bit w, bit r, int a, int d, string req);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = 4'(a); bus_wdata = 8'(d);
    #1;
    if (r) check(int'(bus_rdata), m_read(a), req);
    @(posedge clk);
    m_apply(w, r, a, d);
  endtask

  task automatic wr(int a, int d, string req); op(1, 0, a, d, req); endtask
  task automatic rd(int a, string req);        op(0, 1, a, 0, req); endtask

  // compare registered outputs against the model on every clock
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(int'(pixel_fmt), m_fmt, "R10 pixel_fmt");
      check(int'(dac_6bit), m_six(), "R6 dac_6bit");
      check(int'(mem_size), (m_reg[12] / 4) % 4, "R11 mem_size");
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int codes [12] = '{'h82, 'h83, 'hA0, 'hA1, 'hB1, 'hC0, 'hD0, 'hE2, 'hF2, 'h00, 'h84, 'hFF};
    m_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk_on = 1;

    // R1 reset state
    rd(2, "R1 mask");
    rd(0, "R1 widx");
    rd(3, "R1 ridx");
    rd(5, "R1 reg5");
    rd(11, "R1 mode reg");

    // R9 / R10 mode decode, R7 readback of the mode register
    foreach (codes[i]) begin
      wr(11, codes[i], "R9");
      rd(11, "R7 mode readback");
    end
    wr(11, 'hE2, "R9");

    // R7 low addresses leave the outputs alone
    wr(0, 'hF2, "R7");
    wr(3, 'h0D, "R7");
    wr(2, 'h5C, "R5");
    rd(2, "R5 mask");
    wr(2, 'hFF, "R5");

    // R7 general registers
    for (int a = 5; a < 16; a++) begin
      if (a != 6 && a != 8 && a != 10 && a != 15 && a != 12 && a != 11) begin
        wr(a, 'h5A + a, "R7");
        rd(a, "R7 readback");
      end
    end

    // R8 fixed readbacks
    wr(4, 'h77, "R8"); wr(6, 'h77, "R8"); wr(8, 'h77, "R8");
    wr(10, 'h77, "R8"); wr(15, 'h77, "R8");
    rd(4, "R8 id4"); rd(6, "R8 id6"); rd(8, "R8 id8");
    rd(10, "R8 idA"); rd(15, "R8 idF");

    // R11 memory size field
    wr(12, 'h04, "R11"); wr(12, 'h08, "R11"); wr(12, 'h0C, "R11"); wr(12, 'h00, "R11");

    // R3 / R4 triplet sequencing, R2 index readback
    wr(0, 'h10, "R2");
    for (int k = 0; k < 6; k++) wr(1, 'hC1 + 7 * k, "R3");
    rd(0, "R2 widx after two entries");
    wr(3, 'h10, "R2");
    for (int k = 0; k < 6; k++) rd(1, "R4 palette read");
    rd(3, "R2 ridx after two entries");

    // R3 / R4 index wrap at 255
    wr(0, 'hFF, "R3");
    for (int k = 0; k < 6; k++) wr(1, 'h90 + k, "R3");
    rd(0, "R3 widx wrap");
    wr(3, 'hFF, "R4");
    for (int k = 0; k < 6; k++) rd(1, "R4 wrap read");
    rd(3, "R4 ridx wrap");

    // R2 index write restarts at red mid-triplet
    wr(0, 'h05, "R2");
    wr(1, 'h11, "R2"); wr(1, 'h22, "R2");
    wr(0, 'h07, "R2");
    wr(1, 'hA3, "R2"); wr(1, 'hB4, "R2"); wr(1, 'hE5, "R2");
    wr(3, 'h07, "R2");
    rd(1, "R2 red restart"); rd(1, "R2 green"); rd(1, "R2 blue");
    wr(3, 'h07, "R2");
    rd(1, "R2 partial"); rd(1, "R2 partial");
    wr(3, 'h07, "R2");
    rd(1, "R2 read restart");

    // R6 6-bit mode: trim on write and on read
    wr(12, 'h01, "R6");
    wr(0, 'h20, "R6");
    wr(1, 'hFF, "R6"); wr(1, 'hC0, "R6"); wr(1, 'h81, "R6");
    wr(3, 'h20, "R6");
    rd(1, "R6 six write"); rd(1, "R6 six write"); rd(1, "R6 six write");
    wr(3, 'h10, "R6");
    for (int k = 0; k < 3; k++) rd(1, "R6 six read of 8-bit data");
    wr(12, 'h00, "R6");
    wr(3, 'h10, "R6");
    for (int k = 0; k < 3; k++) rd(1, "R6 eight-bit read");

    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule